// File: doc/BRIEF.md
# Ethernet Transmit Error Sequencer

This block watches a MAC transmit path while a frame is on the wire and decides what happens when something goes wrong. It sorts faults into two classes. A FIFO underrun, an exhausted retry budget or a collision past a programmable byte window is fatal. The buffer is closed with one status bit, a sticky error event is raised, and the transmitter freezes until software sends a restart command. An underrun first drives a deliberately corrupt 32-bit tail, so the far end rejects the frame on its CRC. Loss of carrier sense is not fatal. The frame runs to its normal end and is flagged only if no collision was seen in it. It never leads to a retry.

The MAC pulses `frameStart` to open a buffer, `txByteTick` for each byte sent and `frameEnd` when the frame completes. Collisions inside the window are handed on through `passCollision` to the external backoff logic. The block never gates collisions itself; it only classifies them.

Top module: `tx_fault_sequencer`

## Requirements
- R1: On a `fifoUnderrun` sampled during a frame, `forceBadTail` is high for exactly TAIL_BITS/BEAT_W consecutive cycles (4 with the defaults), starting the cycle after the underrun was sampled.
- R2: In the cycle right after the last tail cycle, `bufClose` pulses, `statUnderrun`, `txErrEvent` and `txHalted` are 1.
- R3: A frame in which `carrierSense` was low and no collision occurred closes only at `frameEnd`, with `statCarrierLost` and `txErrEvent` set. `txHalted` stays 0 and `passCollision` is never raised by the carrier loss.
- R4: A frame in which the carrier dropped but a collision also occurred closes with no status bit set and with `txErrEvent` unchanged.
- R5: `retryExhausted` during a frame closes the buffer in the next cycle, with `statRetryLimit`, `txErrEvent` and `txHalted` set.
- R6: A `collision` sampled when the frame's byte count (ticks since `frameStart`) is at least `lateWindow` closes the buffer in the next cycle, with `statLateColl`, `txErrEvent` and `txHalted` set.
- R7: A `collision` below the window raises `passCollision` in the same cycle. It sets no status bit and no event, and the frame continues.
- R8: Once halted, the block stays halted and ignores `frameStart` until `restartCmd` is seen. The cycle after `restartCmd`, `txHalted` is 0 and a new frame is accepted.
- R9: `restartCmd` while not halted has no effect; a frame in progress still closes normally at `frameEnd`.
- R10: `txErrEvent` stays 1 until `errClear` is pulsed. When a new error and `errClear` arrive in the same cycle, the event stays 1.
- R11: When several fatal faults are sampled in the same cycle, the priority is underrun, then late collision, then retry limit. Only the winning status bit is set.
- R12: `bufClose` is a one-cycle pulse. The status bits hold their values until the next accepted `frameStart`, which clears all four.
- R13: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Strobe: MAC opens a new buffer |
| frameEnd | input | 1 | Strobe: frame finished on the wire |
| txByteTick | input | 1 | Strobe: one byte sent |
| fifoUnderrun | input | 1 | Transmit FIFO ran dry |
| carrierSense | input | 1 | Carrier sense level from the PHY side |
| collision | input | 1 | Collision strobe |
| retryExhausted | input | 1 | Strobe: retry budget used up |
| lateWindow | input | CNT_W | Byte count from which a collision is late |
| restartCmd | input | 1 | Software restart-transmit strobe |
| errClear | input | 1 | Write-one-to-clear for the error event |
| passCollision | output | 1 | Ordinary collision forwarded to retry logic |
| forceBadTail | output | 1 | Drive the corrupting tail onto the wire |
| bufClose | output | 1 | One-cycle buffer close strobe |
| statUnderrun | output | 1 | Buffer status: underrun |
| statCarrierLost | output | 1 | Buffer status: carrier lost |
| statRetryLimit | output | 1 | Buffer status: retry limit |
| statLateColl | output | 1 | Buffer status: late collision |
| txErrEvent | output | 1 | Sticky transmit error event |
| txHalted | output | 1 | Transmitter frozen awaiting restart |

## Verification
The bench places a collision one byte below the window and then exactly on it. A comparator that is off by one would forward the late collision as an ordinary one, or halt on an early one. It raises underrun, late collision and retry limit in the same cycle. A design with the wrong priority would close with two status bits, or with the wrong one. It also counts the tail cycles one by one, which exposes a tail that is one beat short or one beat long. It pulses `frameStart` and `restartCmd` in the states where each must do nothing. A design that leaks either would clear the status or drop a live frame. Finally, it raises an error event in the same cycle as its clear, and a design in which the clear wins would lose that event.

// File: rtl/tx_fault_pkg.sv
package tx_fault_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_TAIL   = 2'd2,
    ST_HALT   = 2'd3
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startFrame;
    logic countEn;
    logic loadTail;
    logic tailRun;
    logic closeUnderrun;
    logic closeLate;
    logic closeRetry;
    logic closeNormal;
  } ctlStrobe_t;
endpackage

// File: rtl/tx_fault_ctrl.sv
module tx_fault_ctrl
  import tx_fault_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic       frameEnd,
  input  logic       fifoUnderrun,
  input  logic       collision,
  input  logic       retryExhausted,
  input  logic       restartCmd,
  input  logic       lateHit,
  input  logic       tailDone,
  output ctlStrobe_t ctl,
  output logic       passCollision,
  output logic       forceBadTail,
  output logic       txHalted
);
  txState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext     = state;
    ctl           = '0;
    passCollision = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (frameStart) begin
          ctl.startFrame = 1'b1;
          stateNext      = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        ctl.countEn = 1'b1;
        if (fifoUnderrun) begin
          ctl.loadTail = 1'b1;
          stateNext    = ST_TAIL;
        end else if (collision && lateHit) begin
          ctl.closeLate = 1'b1;
          stateNext     = ST_HALT;
        end else if (retryExhausted) begin
          ctl.closeRetry = 1'b1;
          stateNext      = ST_HALT;
        end else begin
          passCollision = collision;
          if (frameEnd) begin
            ctl.closeNormal = 1'b1;
            stateNext       = ST_IDLE;
          end
        end
      end
      ST_TAIL: begin
        ctl.tailRun = 1'b1;
        if (tailDone) begin
          ctl.closeUnderrun = 1'b1;
          stateNext         = ST_HALT;
        end
      end
      ST_HALT: begin
        if (restartCmd) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign forceBadTail = (state == ST_TAIL);
  assign txHalted     = (state == ST_HALT);
endmodule

// File: rtl/tx_fault_dp.sv
module tx_fault_dp
  import tx_fault_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int TAIL_BEATS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  input  logic             txByteTick,
  input  logic             collision,
  input  logic             carrierSense,
  input  logic [CNT_W-1:0] lateWindow,
  input  logic             errClear,
  output logic             lateHit,
  output logic             tailDone,
  output logic             bufClose,
  output logic             statUnderrun,
  output logic             statCarrierLost,
  output logic             statRetryLimit,
  output logic             statLateColl,
  output logic             txErrEvent
);
  localparam int TAIL_CW = (TAIL_BEATS > 1) ? $clog2(TAIL_BEATS) : 1;
  localparam logic [TAIL_CW-1:0] TAIL_LOAD = TAIL_CW'(TAIL_BEATS - 1);

  logic [CNT_W-1:0]   byteCnt;
  logic [TAIL_CW-1:0] tailCnt;
  logic               sawCollision, carrierDrop;
  logic               lostNow, collSeen, reportLost, errSet;

  always_ff @(posedge clk) begin
    if (!rstN)                                       byteCnt <= '0;
    else if (ctl.startFrame)                         byteCnt <= '0;
    else if (ctl.countEn && txByteTick && byteCnt != '1) byteCnt <= byteCnt + 1'b1;
  end

  assign lateHit = (byteCnt >= lateWindow);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.startFrame) begin
      sawCollision <= 1'b0;
      carrierDrop  <= 1'b0;
    end else if (ctl.countEn) begin
      if (collision)     sawCollision <= 1'b1;
      if (!carrierSense) carrierDrop  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                             tailCnt <= '0;
    else if (ctl.loadTail)                 tailCnt <= TAIL_LOAD;
    else if (ctl.tailRun && tailCnt != '0) tailCnt <= tailCnt - 1'b1;
  end

  assign tailDone = (tailCnt == '0);

  assign lostNow    = carrierDrop | ~carrierSense;
  assign collSeen   = sawCollision | collision;
  assign reportLost = ctl.closeNormal & lostNow & ~collSeen;
  assign errSet     = ctl.closeUnderrun | ctl.closeLate | ctl.closeRetry | reportLost;

  always_ff @(posedge clk) begin
    if (!rstN || ctl.startFrame) begin
      statUnderrun    <= 1'b0;
      statCarrierLost <= 1'b0;
      statRetryLimit  <= 1'b0;
      statLateColl    <= 1'b0;
    end else begin
      if (ctl.closeUnderrun) statUnderrun    <= 1'b1;
      if (reportLost)        statCarrierLost <= 1'b1;
      if (ctl.closeRetry)    statRetryLimit  <= 1'b1;
      if (ctl.closeLate)     statLateColl    <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufClose   <= 1'b0;
      txErrEvent <= 1'b0;
    end else begin
      bufClose <= ctl.closeUnderrun | ctl.closeLate | ctl.closeRetry | ctl.closeNormal;
      if (errSet)        txErrEvent <= 1'b1;
      else if (errClear) txErrEvent <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_fault_sequencer.sv
module tx_fault_sequencer
  import tx_fault_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BEAT_W    = 8,
  parameter int TAIL_BITS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             frameEnd,
  input  logic             txByteTick,
  input  logic             fifoUnderrun,
  input  logic             carrierSense,
  input  logic             collision,
  input  logic             retryExhausted,
  input  logic [CNT_W-1:0] lateWindow,
  input  logic             restartCmd,
  input  logic             errClear,
  output logic             passCollision,
  output logic             forceBadTail,
  output logic             bufClose,
  output logic             statUnderrun,
  output logic             statCarrierLost,
  output logic             statRetryLimit,
  output logic             statLateColl,
  output logic             txErrEvent,
  output logic             txHalted
);
  localparam int TAIL_BEATS = TAIL_BITS / BEAT_W;

  ctlStrobe_t ctl;
  logic       lateHit, tailDone;

  tx_fault_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .frameStart(frameStart), .frameEnd(frameEnd),
    .fifoUnderrun(fifoUnderrun), .collision(collision),
    .retryExhausted(retryExhausted), .restartCmd(restartCmd),
    .lateHit(lateHit), .tailDone(tailDone),
    .ctl(ctl), .passCollision(passCollision),
    .forceBadTail(forceBadTail), .txHalted(txHalted)
  );

  tx_fault_dp #(.CNT_W(CNT_W), .TAIL_BEATS(TAIL_BEATS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .txByteTick(txByteTick), .collision(collision),
    .carrierSense(carrierSense), .lateWindow(lateWindow),
    .errClear(errClear), .lateHit(lateHit), .tailDone(tailDone),
    .bufClose(bufClose), .statUnderrun(statUnderrun),
    .statCarrierLost(statCarrierLost), .statRetryLimit(statRetryLimit),
    .statLateColl(statLateColl), .txErrEvent(txErrEvent)
  );
endmodule

// File: rtl/tx_fault_chk.sv
module tx_fault_chk (
  input logic clk,
  input logic rstN,
  input logic restartCmd,
  input logic errClear,
  input logic passCollision,
  input logic forceBadTail,
  input logic bufClose,
  input logic statUnderrun,
  input logic statCarrierLost,
  input logic statRetryLimit,
  input logic statLateColl,
  input logic txErrEvent,
  input logic txHalted
);
  // R12
  close_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufClose |=> !bufClose);

  // R11
  one_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({statUnderrun, statCarrierLost, statRetryLimit, statLateColl}));

  // R2
  tail_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(forceBadTail) |-> (bufClose && statUnderrun && txHalted));

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txHalted && !restartCmd) |=> txHalted);

  // R10
  event_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txErrEvent && !errClear) |=> txErrEvent);

  // R5
  fatal_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufClose && (statUnderrun || statRetryLimit || statLateColl)) |-> (txHalted && txErrEvent));

  // R7
  pass_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    passCollision |-> (!txHalted && !forceBadTail));
endmodule

bind tx_fault_sequencer tx_fault_chk u_chk (
  .clk(clk), .rstN(rstN), .restartCmd(restartCmd), .errClear(errClear),
  .passCollision(passCollision), .forceBadTail(forceBadTail),
  .bufClose(bufClose), .statUnderrun(statUnderrun),
  .statCarrierLost(statCarrierLost), .statRetryLimit(statRetryLimit),
  .statLateColl(statLateColl), .txErrEvent(txErrEvent), .txHalted(txHalted)
);

// File: tb/tx_fault_sequencer_tb.sv
module tx_fault_sequencer_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 0, frameEnd = 0, txByteTick = 0, fifoUnderrun = 0;
  logic carrierSense = 1, collision = 0, retryExhausted = 0;
  logic restartCmd = 0, errClear = 0;
  logic [CNT_W-1:0] lateWindow = 16'd8;
  logic passCollision, forceBadTail, bufClose, statUnderrun, statCarrierLost;
  logic statRetryLimit, statLateColl, txErrEvent, txHalted;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tx_fault_sequencer u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameEnd(frameEnd),
    .txByteTick(txByteTick), .fifoUnderrun(fifoUnderrun),
    .carrierSense(carrierSense), .collision(collision),
    .retryExhausted(retryExhausted), .lateWindow(lateWindow),
    .restartCmd(restartCmd), .errClear(errClear),
    .passCollision(passCollision), .forceBadTail(forceBadTail),
    .bufClose(bufClose), .statUnderrun(statUnderrun),
    .statCarrierLost(statCarrierLost), .statRetryLimit(statRetryLimit),
    .statLateColl(statLateColl), .txErrEvent(txErrEvent), .txHalted(txHalted)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // status packed as {underrun, carrierLost, retry, late}
  function automatic int statVec();
    return {statUnderrun, statCarrierLost, statRetryLimit, statLateColl};
  endfunction

  task automatic pulseStart();
    frameStart = 1; @(negedge clk); frameStart = 0;
  endtask
  task automatic pulseEnd();
    frameEnd = 1; @(negedge clk); frameEnd = 0;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      txByteTick = 1; @(negedge clk); txByteTick = 0;
    end
  endtask
  task automatic restart();
    restartCmd = 1; @(negedge clk); restartCmd = 0;
    check("R8 halted cleared by restart", txHalted, 0);
  endtask
  task automatic clearEvent();
    errClear = 1; @(negedge clk); errClear = 0;
    check("R10 event cleared", txErrEvent, 0);
  endtask

  task automatic testReset();
    check("R13 reset outputs", {passCollision, forceBadTail, bufClose, txErrEvent, txHalted}, 0);
    check("R13 reset status", statVec(), 0);
  endtask

  task automatic testUnderrun();
    int cnt;
    pulseStart(); ticks(3);
    fifoUnderrun = 1; @(negedge clk); fifoUnderrun = 0;
    cnt = 0;
    while (forceBadTail && cnt < 20) begin
      check("R1 no close during tail", bufClose, 0);
      cnt++; @(negedge clk);
    end
    check("R1 tail length", cnt, 4);
    check("R2 close after tail", bufClose, 1);
    check("R2 underrun status", statVec(), 8);
    check("R2 event", txErrEvent, 1);
    check("R2 halted", txHalted, 1);
    @(negedge clk);
    check("R12 close one cycle", bufClose, 0);
    check("R12 status held", statVec(), 8);
    restart(); clearEvent();
  endtask

  task automatic testCarrierLost();
    pulseStart(); ticks(2);
    carrierSense = 0;
    for (int i = 0; i < 2; i++) begin
      #1 check("R3 no pass on carrier loss", passCollision, 0);
      @(negedge clk);
    end
    carrierSense = 1;
    check("R3 not closed early", bufClose, 0);
    ticks(3);
    check("R3 not halted", txHalted, 0);
    // set wins over simultaneous clear
    errClear = 1; pulseEnd(); errClear = 0;
    check("R3 close at end", bufClose, 1);
    check("R3 carrier status", statVec(), 4);
    check("R10 set beats clear", txErrEvent, 1);
    check("R3 not halted after close", txHalted, 0);
    // a clean frame keeps the sticky event
    pulseStart();
    check("R12 status cleared by start", statVec(), 0);
    ticks(2); pulseEnd();
    check("R10 event sticky", txErrEvent, 1);
    clearEvent();
  endtask

  task automatic testCarrierWithCollision();
    pulseStart(); ticks(1);
    collision = 1; #1 check("R7 early collision passed", passCollision, 1);
    @(negedge clk); collision = 0;
    carrierSense = 0; @(negedge clk); carrierSense = 1;
    pulseEnd();
    check("R4 close", bufClose, 1);
    check("R4 no status", statVec(), 0);
    check("R4 no event", txErrEvent, 0);
  endtask

  task automatic testRetry();
    pulseStart(); ticks(2);
    retryExhausted = 1; @(negedge clk); retryExhausted = 0;
    check("R5 close", bufClose, 1);
    check("R5 retry status", statVec(), 2);
    check("R5 event", txErrEvent, 1);
    check("R5 halted", txHalted, 1);
    // frame start while halted ignored
    pulseStart();
    check("R8 start ignored status", statVec(), 2);
    check("R8 still halted", txHalted, 1);
    restart(); clearEvent();
    pulseStart();
    check("R8 frame accepted after restart", statVec(), 0);
    pulseEnd();
  endtask

  task automatic testLateBoundary();
    pulseStart(); ticks(7);
    collision = 1; #1 check("R7 below window passed", passCollision, 1);
    @(negedge clk); collision = 0;
    check("R7 no close", bufClose, 0);
    check("R7 no halt", txHalted, 0);
    check("R7 no event", txErrEvent, 0);
    ticks(1);
    collision = 1; #1 check("R6 at window not passed", passCollision, 0);
    @(negedge clk); collision = 0;
    check("R6 close", bufClose, 1);
    check("R6 late status", statVec(), 1);
    check("R6 event", txErrEvent, 1);
    check("R6 halted", txHalted, 1);
    restart(); clearEvent();
  endtask

  task automatic testPriority();
    int cnt;
    pulseStart(); ticks(9);
    fifoUnderrun = 1; collision = 1; retryExhausted = 1;
    @(negedge clk);
    fifoUnderrun = 0; collision = 0; retryExhausted = 0;
    cnt = 0;
    while (forceBadTail && cnt < 20) begin cnt++; @(negedge clk); end
    check("R11 underrun wins tail", cnt, 4);
    check("R11 underrun only", statVec(), 8);
    restart(); clearEvent();
    pulseStart(); ticks(9);
    collision = 1; retryExhausted = 1; @(negedge clk);
    collision = 0; retryExhausted = 0;
    check("R11 late over retry", statVec(), 1);
    restart(); clearEvent();
  endtask

  task automatic testRestartIgnored();
    pulseStart(); ticks(1);
    restartCmd = 1; @(negedge clk); restartCmd = 0;
    check("R9 no close on stray restart", bufClose, 0);
    ticks(1); pulseEnd();
    check("R9 frame closes normally", bufClose, 1);
    check("R9 clean status", statVec(), 0);
    check("R9 not halted", txHalted, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testReset();
    testUnderrun();
    testCarrierLost();
    testCarrierWithCollision();
    testRetry();
    testLateBoundary();
    testPriority();
    testRestartIgnored();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule